// File: doc/BRIEF.md
# Configurable GPIO Port with Peripheral Override

This block controls one bidirectional I/O port of a small microcontroller. Software reaches it through a simple register bus. It holds an output latch, a direction register, a single port-wide output-type select and a set of pull-up enables. Direction is set per group of pins. The group width is a parameter: 4 gives nibble control and 1 gives per-bit control. The pad side of the block presents a drive value, an output enable and a pull-up request for each pin, and it accepts the level sensed at each pin.

Reading the data register returns the level actually present at the pins, taken through a two-flop synchronizer. It never returns the latch. An AND, OR or XOR done as read-modify-write therefore works on the pin levels. In open-drain mode a latch 1 releases the pin, so an undriven released pin reads back as 0. One pin, the top one by default, can be taken over by a serial transmitter's output whenever the transmitter is enabled and that pin's group is set as output. A stop-mode resume pulse returns every pin to input without touching the other registers.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an input (DIR register reads all ones, `pad_oe` = 0), the latch is 0, CFG reads 0, PULL reads 0 and `pad_pu` = 0.
- R2: DIR (address 1) bit k controls pins k*GRP_W to k*GRP_W+GRP_W-1. A value of 1 means input and 0 means output. In push-pull mode `pad_oe` is set exactly on the output pins.
- R3: In push-pull mode (CFG bit 2 = 0), `pad_out` equals the pin's drive value on output pins and is 0 on input pins.
- R4: In open-drain mode (CFG bit 2 = 1), `pad_out` is 0 for every pin, and `pad_oe` is set only on output pins whose drive value is 0.
- R5: A read of PIN (address 0) returns `pad_in` as sampled two rising edges earlier. It never returns the latch value. A write to address 0 loads the latch.
- R6: `pad_pu` equals PULL (address 3) AND input mode for each pin, so pull-ups are off on every output pin.
- R7: When `ovr_en` = 1 and the group of pin OVR_BIT is output, that pin's drive value is `ovr_data` instead of the latch bit, in both output types. The other pins are not affected.
- R8: When the group of pin OVR_BIT is input, `ovr_en` has no effect on `pad_oe` or `pad_out`.
- R9: A `stop_resume` pulse sets DIR to all ones (all inputs) at the next edge. It takes priority over a DIR write in the same cycle. The latch, CFG and PULL keep their values.
- R10: Reading CFG (address 2) returns only bit 2. All other CFG bits read 0. DIR and PULL read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_resume | input | 1 | Stop-mode recovery pulse; forces all pins to input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 PIN/latch, 1 DIR, 2 CFG, 3 PULL |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Combinational read data for `addr` |
| pad_in | input | WIDTH | Level sensed at each pin |
| pad_out | output | WIDTH | Drive value per pin |
| pad_oe | output | WIDTH | Output enable per pin |
| pad_pu | output | WIDTH | Pull-up enable per pin |
| ovr_en | input | 1 | Serial transmitter enabled; takes over pin OVR_BIT |
| ovr_data | input | 1 | Serial transmit data |

## Verification
The bench builds two copies of the block with WIDTH = 8. The first uses GRP_W = 4 and carries all the random and directed checks. The second uses GRP_W = 1 and shares the same register bus, so the per-bit variant of the direction mapping can be checked against an irregular DIR pattern. With the nibble build, the random runs cover mixed input/output nibbles in both output types while the override toggles. The bench's pin model, which covers driven levels, external drive and floating pins with or without pull-up, makes the read-back of open-drain released pins visible.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      REG_PIN  = 2'd0,
      REG_DIR  = 2'd1,
      REG_CFG  = 2'd2,
      REG_PULL = 2'd3
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_dir_map.sv
module gpio_dir_map #(
   parameter int WIDTH = 8,
   parameter int GRP_W = 4,
   localparam int MODE_W = WIDTH / GRP_W
) (
   input  logic [MODE_W-1:0] dir_in,
   output logic [WIDTH-1:0]  is_out
);
   generate
      if (GRP_W == 1) begin : g_per_bit
         assign is_out = ~dir_in;
      end else begin : g_per_group
         for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            assign is_out[i] = ~dir_in[i / GRP_W];
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
   parameter int WIDTH   = 8,
   parameter int OVR_BIT = WIDTH - 1
) (
   input  logic [WIDTH-1:0] latch,
   input  logic [WIDTH-1:0] is_out,
   input  logic             od_mode,
   input  logic [WIDTH-1:0] pull_en,
   input  logic             ovr_en,
   input  logic             ovr_data,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         logic drv;
         if (i == OVR_BIT) begin : g_ovr
            assign drv = ovr_en ? ovr_data : latch[i];
         end else begin : g_plain
            assign drv = latch[i];
         end
         assign pad_out[i] = is_out[i] & ~od_mode & drv;
         assign pad_oe[i]  = is_out[i] & (~od_mode | ~drv);
         assign pad_pu[i]  = pull_en[i] & ~is_out[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int GRP_W       = 4,
   parameter int OD_BIT      = 2,
   parameter int OVR_BIT     = WIDTH - 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_resume,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu,
   input  logic             ovr_en,
   input  logic             ovr_data
);
   localparam int MODE_W = WIDTH / GRP_W;

   generate
      if ((WIDTH % GRP_W) != 0) begin : g_bad_grp
         $error("gpio_port: WIDTH must be a multiple of GRP_W");
      end
      if (OD_BIT >= WIDTH || OVR_BIT >= WIDTH) begin : g_bad_bit
         $error("gpio_port: OD_BIT and OVR_BIT must lie inside WIDTH");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0]  latch_q;
   logic [MODE_W-1:0] dir_q;
   logic              od_q;
   logic [WIDTH-1:0]  pull_q;
   logic [WIDTH-1:0]  is_out;
   logic [WIDTH-1:0]  pin_sync;
   gpio_reg_e         sel;

   assign sel = gpio_reg_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '1;
         od_q    <= 1'b0;
         pull_q  <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               REG_PIN:  latch_q <= wdata;
               REG_DIR:  dir_q   <= wdata[MODE_W-1:0];
               REG_CFG:  od_q    <= wdata[OD_BIT];
               REG_PULL: pull_q  <= wdata;
               default:  ;
            endcase
         end
         if (stop_resume) dir_q <= '1;
      end
   end

   gpio_dir_map #(.WIDTH(WIDTH), .GRP_W(GRP_W)) u_dir (
      .dir_in (dir_q),
      .is_out (is_out)
   );

   gpio_pad_drv #(.WIDTH(WIDTH), .OVR_BIT(OVR_BIT)) u_drv (
      .latch    (latch_q),
      .is_out   (is_out),
      .od_mode  (od_q),
      .pull_en  (pull_q),
      .ovr_en   (ovr_en),
      .ovr_data (ovr_data),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe),
      .pad_pu   (pad_pu)
   );

   gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   always_comb begin
      rdata = '0;
      case (sel)
         REG_PIN:  rdata = pin_sync;
         REG_DIR:  rdata[MODE_W-1:0] = dir_q;
         REG_CFG:  rdata[OD_BIT] = od_q;
         REG_PULL: rdata = pull_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop_resume,
   input logic [1:0]       addr,
   input logic [WIDTH-1:0] rdata,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_pu,
   input logic             od_q
);
   logic [1:0] settle;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             settle <= '0;
      else if (settle != 2'd3) settle <= settle + 2'd1;

   AST_RST_ALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (settle == 2'd0) |-> (pad_oe == '0 && pad_pu == '0)); // R1

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      od_q |-> (pad_out == '0)); // R4

   AST_PIN_TWO_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
      (settle >= 2'd2 && addr == 2'd0) |-> (rdata == $past(pad_in, 2))); // R5

   AST_NO_PULL_ON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_oe) == '0)); // R6

   AST_RESUME_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_resume |=> (pad_oe == '0 && pad_out == '0)); // R9
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_resume (stop_resume),
   .addr        (addr),
   .rdata       (rdata),
   .pad_in      (pad_in),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .pad_pu      (pad_pu),
   .od_q        (od_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, stop_resume, wr_en, ovr_en, ovr_data;
   logic [1:0] addr;
   logic [7:0] wdata, rdata, pad_in, pad_out, pad_oe, pad_pu;
   logic [7:0] b_rdata, b_pad_out, b_pad_oe, b_pad_pu;
   logic [7:0] ext_en, ext_val;

   int nchk = 0, nerr = 0;
   bit done = 0;

   // bench model state
   logic [7:0] m_lat, m_pull;
   logic [1:0] m_dir;
   logic       m_od;

   gpio_port #(.WIDTH(8), .GRP_W(4)) dut (
      .clk, .rst_n, .stop_resume, .wr_en, .addr, .wdata, .rdata,
      .pad_in, .pad_out, .pad_oe, .pad_pu, .ovr_en, .ovr_data
   );

   gpio_port #(.WIDTH(8), .GRP_W(1)) dut_bit (
      .clk, .rst_n, .stop_resume, .wr_en, .addr, .wdata, .rdata(b_rdata),
      .pad_in(b_pad_out), .pad_out(b_pad_out), .pad_oe(b_pad_oe), .pad_pu(b_pad_pu),
      .ovr_en(1'b0), .ovr_data(1'b0)
   );

   // pin resolution: driven level, else external drive, else pull-up or float-low
   always_comb
      for (int i = 0; i < 8; i++)
         pad_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : pad_pu[i]);

   function automatic logic [7:0] e_mask();
      return {{4{~m_dir[1]}}, {4{~m_dir[0]}}};
   endfunction
   function automatic logic [7:0] e_val();
      logic [7:0] v = m_lat;
      if (ovr_en) v[7] = ovr_data;
      return v;
   endfunction
   function automatic logic [7:0] e_oe();
      return e_mask() & (m_od ? ~e_val() : 8'hFF);
   endfunction
   function automatic logic [7:0] e_out();
      return m_od ? 8'h00 : (e_mask() & e_val());
   endfunction
   function automatic logic [7:0] e_pu();
      return m_pull & ~e_mask();
   endfunction
   function automatic logic [7:0] e_pin();
      logic [7:0] p, oe, o, pu;
      oe = e_oe(); o = e_out(); pu = e_pu();
      for (int i = 0; i < 8; i++) p[i] = oe[i] ? o[i] : (ext_en[i] ? ext_val[i] : pu[i]);
      return p;
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_pads();
      chk(m_od ? "R4" : "R2", "pad_oe", pad_oe, e_oe());
      chk(m_od ? "R4" : "R3", "pad_out", pad_out, e_out());
      chk("R6", "pad_pu", pad_pu, e_pu());
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a; #1; d = rdata;
   endtask

   // called at a negedge; returns at the next negedge with the write committed
   task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit resume);
      wr_en = 1'b1; addr = a; wdata = d; stop_resume = resume;
      @(negedge clk);
      wr_en = 1'b0; stop_resume = 1'b0;
      case (a)
         2'd0: m_lat = d;
         2'd1: m_dir = d[1:0];
         2'd2: m_od = d[2];
         default: m_pull = d;
      endcase
      if (resume) m_dir = 2'b11;
   endtask

   task automatic check_pin();
      logic [7:0] d;
      repeat (2) @(negedge clk);
      rd(2'd0, d);
      chk("R5", "pin read", d, e_pin());
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h5EED_0C4A));
      rst_n = 0; stop_resume = 0; wr_en = 0; addr = 0; wdata = 0;
      ovr_en = 0; ovr_data = 0; ext_en = 0; ext_val = 0;
      m_lat = 0; m_pull = 0; m_dir = 2'b11; m_od = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "pad_oe", pad_oe, 8'h00);
      chk("R1", "pad_pu", pad_pu, 8'h00);
      rd(2'd1, d); chk("R1", "dir", d, 8'h03);
      rd(2'd2, d); chk("R1", "cfg", d, 8'h00);
      rd(2'd3, d); chk("R1", "pull", d, 8'h00);

      // R10 cfg readback holds only bit 2
      wr(2'd2, 8'hFF, 0);
      rd(2'd2, d); chk("R10", "cfg read", d, 8'h04);
      wr(2'd2, 8'h00, 0);
      wr(2'd3, 8'hA6, 0);
      rd(2'd3, d); chk("R10", "pull read", d, 8'hA6);

      // R5 pin read returns pins, not latch: all inputs, latch differs from pins
      wr(2'd0, 8'hFF, 0);
      ext_en = 8'hFF; ext_val = 8'h3C;
      check_pin();
      ext_en = 8'h00;

      // R2 nibble direction, push-pull
      wr(2'd1, 8'h02, 0);   // low nibble out, high in
      check_pads();
      chk("R2", "low nibble oe", pad_oe, 8'h0F);
      // R2 per-bit variant
      wr(2'd1, 8'h5A, 0);
      m_dir = 2'b10;
      chk("R2", "per-bit oe", b_pad_oe, 8'hA5);
      chk("R3", "per-bit out", b_pad_out, 8'hA5);

      // R4 open drain: released pins float low, read 0
      wr(2'd1, 8'h00, 0);
      wr(2'd0, 8'hA5, 0);
      wr(2'd2, 8'h04, 0);
      chk("R4", "od oe", pad_oe, 8'h5A);
      chk("R4", "od out", pad_out, 8'h00);
      check_pin();
      ext_en = 8'hFF; ext_val = 8'hFF;
      check_pin();
      ext_en = 8'h00;

      // R7 override in push-pull and open-drain
      wr(2'd2, 8'h00, 0);
      wr(2'd0, 8'h00, 0);
      ovr_en = 1; ovr_data = 1; #1;
      chk("R7", "pp ovr high", pad_out, 8'h80);
      wr(2'd0, 8'hFF, 0);
      ovr_data = 0; #1;
      chk("R7", "pp ovr low", pad_out, 8'h7F);
      wr(2'd2, 8'h04, 0);
      chk("R7", "od ovr low oe", pad_oe, 8'h80);

      // R8 override ignored when top nibble is input
      wr(2'd2, 8'h00, 0);
      wr(2'd1, 8'h02, 0);
      ovr_data = 1; #1;
      chk("R8", "ovr oe", pad_oe, 8'h0F);
      chk("R8", "ovr out", pad_out, 8'h0F);
      ovr_en = 0; ovr_data = 0;

      // R9 stop resume beats same-cycle dir write; other state retained
      wr(2'd0, 8'h3C, 0);
      wr(2'd3, 8'hFF, 0);
      wr(2'd1, 8'h00, 0);
      wr(2'd1, 8'h00, 1);
      chk("R9", "resume oe", pad_oe, 8'h00);
      chk("R9", "resume pu", pad_pu, 8'hFF);
      rd(2'd1, d); chk("R9", "resume dir", d, 8'h03);
      rd(2'd3, d); chk("R9", "resume pull", d, 8'hFF);
      wr(2'd1, 8'h00, 0);
      chk("R9", "latch kept", pad_out, 8'h3C);

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [1:0] a;
         a = 2'($urandom_range(0, 3));
         ovr_en = 1'($urandom); ovr_data = 1'($urandom);
         ext_en = 8'($urandom); ext_val = 8'($urandom);
         wr(a, 8'($urandom), 1'($urandom_range(0, 15) == 0));
         check_pads();
         if (n % 4 == 0) check_pin();
         if (a == 2'd1) begin
            rd(2'd1, d); chk("R10", "dir read", d, {6'd0, m_dir});
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule